// File: doc/BRIEF.md
# Dual-Mode PWM Timer Channel

This block is one pulse-width modulation channel built around a 16-bit counter. Software-style writes load a shadow period value and a shadow pulse-width value. The channel copies these shadow values into its working registers only at the end of a period, or at any time while it is stopped. This means a running waveform never mixes an old and a new setting within one period.

A mode input selects the counting scheme.

- **Edge-aligned:** the counter climbs from zero to the period value and then wraps back to zero.
- **Centre-aligned:** the counter climbs to the period value and then descends back to zero, which gives a waveform that is symmetric about the middle of the period.

In both schemes the output is high while the count is at or above the pulse width. A width of zero therefore gives full duty, and a width larger than the period gives zero duty.

A prescale select chooses whether the counter advances on every clock or on every 64th clock. A one-clock interrupt strobe marks each period end.

Top module: `pwm_channel`

## Requirements
- R1: After reset, pwm_o and irq_o are low. While en_i is low, pwm_o stays low, irq_o stays low and the counter is held at zero.
- R2: With mode 0 (edge-aligned) latched, the count runs 0,1,...,P and returns to 0 on the next count step, so one period lasts P+1 count steps. pwm_o is high while count >= W, where P is the working period and W is the working width.
- R3: With mode 1 (centre-aligned) latched, the count rises 0..P, holds P for one extra step, falls to 0 and holds 0 for one extra step. One period is 2*(P+1) count steps, and pwm_o is high while count >= W.
- R4: A working width of 0 keeps pwm_o high on every enabled cycle, in both modes.
- R5: A working width greater than the working period keeps pwm_o low on every cycle, in both modes.
- R6: With presc_i=0 the count advances on every enabled clock. With presc_i=1 it advances once every 64 enabled clocks, the first step coming on the 64th clock after enable.
- R7: A write with wr_sel_i=0 loads the period shadow, and a write with wr_sel_i=1 loads the width shadow. The working period, the working width and the latched mode take the shadow values and mode_i only at a period end, or on any clock while en_i is low.
- R8: irq_o is high for exactly one clock after each count step that ends a period, and it is low otherwise.
- R9: The count never exceeds the working period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low stops and clears the counter |
| mode_i | input | 1 | 0 edge-aligned, 1 centre-aligned; latched at reload |
| presc_i | input | 1 | 0 count every clock, 1 count every 64th clock |
| wr_en_i | input | 1 | Shadow register write strobe |
| wr_sel_i | input | 1 | 0 period shadow, 1 width shadow |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | PWM level |
| irq_o | output | 1 | One-clock period-end strobe |

## Verification
On every cycle, the assertions check the following:
- the count stays within the working period;
- the working period changes only when the count is zero;
- the duty boundaries at width zero and at width above the period;
- the edge-mode wrap;
- the single-clock interrupt strobe and its absence while stopped.

Some behaviours can only be shown by the bench's directed scenarios, because they measure high-time and interrupt counts over whole periods:
- the period length and duty in each mode;
- the 64-clock prescale timing;
- the fact that a width written mid-period waits for the period end.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    MODE_EDGE   = 1'b0,
    MODE_CENTRE = 1'b1
  } pwm_mode_e;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int unsigned PC_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(DIV - 1);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (!run_i)            pc_q <= '0;
    else if (pc_q == PC_LAST)   pc_q <= '0;
    else                        pc_q <= pc_q + 1'b1;
  end

  assign tick_o = run_i & (~slow_i | (pc_q == PC_LAST));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             mode_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] act_per_o,
  output logic [CNT_W-1:0] act_wid_o,
  output pwm_mode_e        act_mode_o
);
  logic [CNT_W-1:0] sh_per_q, sh_wid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_per_q <= '0;
      sh_wid_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i) sh_wid_q <= wr_data_i;
      else          sh_per_q <= wr_data_i;
    end
  end

  // active set moves only at period end or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_per_o  <= '0;
      act_wid_o  <= '0;
      act_mode_o <= MODE_EDGE;
    end else if (load_i) begin
      act_per_o  <= sh_per_q;
      act_wid_o  <= sh_wid_q;
      act_mode_o <= pwm_mode_e'(mode_i);
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  pwm_mode_e        mode_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dn_q;

  always_comb begin
    if (mode_i == MODE_EDGE) pend_o = tick_i & (cnt_q == per_i);
    else                     pend_o = tick_i & dn_q & (cnt_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (tick_i) begin
      if (mode_i == MODE_EDGE) begin
        dn_q  <= 1'b0;
        cnt_q <= (cnt_q == per_i) ? '0 : cnt_q + 1'b1;
      end else if (!dn_q) begin
        // top value is held one extra step while direction flips
        if (cnt_q == per_i) dn_q  <= 1'b1;
        else                cnt_q <= cnt_q + 1'b1;
      end else begin
        if (cnt_q == '0) dn_q  <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SLOW_DIV = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             presc_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             irq_o
);
  logic             tick;
  logic             pend;
  logic             load;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_per, act_wid;
  pwm_mode_e        act_mode;
  logic             irq_q;

  assign load = pend | ~en_i;

  pwm_prescale #(.DIV(SLOW_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .slow_i (presc_i),
    .tick_o (tick)
  );

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .mode_i     (mode_i),
    .load_i     (load),
    .act_per_o  (act_per),
    .act_wid_o  (act_wid),
    .act_mode_o (act_mode)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .tick_i (tick),
    .mode_i (act_mode),
    .per_i  (act_per),
    .cnt_o  (cnt),
    .pend_o (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pend;
  end

  assign irq_o = irq_q;
  assign pwm_o = en_i & (cnt >= act_wid);
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             presc_i,
  input logic             pwm_o,
  input logic             irq_o,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_per,
  input logic [CNT_W-1:0] act_wid,
  input logic             act_mode
);
  a_r1_idle_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);

  a_r2_edge_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick && !act_mode && cnt == act_per) |=> (cnt == '0));

  a_r4_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && act_wid == '0) |-> pwm_o);

  a_r5_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_wid > act_per) |-> !pwm_o);

  a_r7_reload_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_per) |-> (cnt == '0));

  a_r8_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && presc_i && $past(presc_i)) |=> !irq_o);

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= act_per);
endmodule

bind pwm_channel pwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .presc_i  (presc_i),
  .pwm_o    (pwm_o),
  .irq_o    (irq_o),
  .tick     (tick),
  .cnt      (cnt),
  .act_per  (act_per),
  .act_wid  (act_wid),
  .act_mode (act_mode)
);

// File: tb/tb_pwm_channel.sv
module tb_pwm_channel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        presc_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        pwm_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  pwm_channel dut (
    .clk_i, .rst_ni, .en_i, .mode_i, .presc_i,
    .wr_en_i, .wr_sel_i, .wr_data_i, .pwm_o, .irq_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic setup(input logic m, input logic ps, input int pp, input int pw);
    @(negedge clk_i);
    en_i = 1'b0; mode_i = m; presc_i = ps;
    wr(1'b0, 16'(pp));
    wr(1'b1, 16'(pw));
    @(negedge clk_i);
  endtask

  // samples n cycles, one time unit after each rising edge
  task automatic window(input int n, output int hi, output int irqs);
    hi = 0; irqs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      hi   += int'(pwm_o);
      irqs += int'(irq_o);
    end
  endtask

  task automatic start();
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic stop();
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset pwm", int'(pwm_o), 0);
    check("R1 reset irq", int'(irq_o), 0);
  endtask

  task automatic t_disabled();
    int hi, ir;
    setup(1'b0, 1'b0, 3, 0);
    window(20, hi, ir);
    check("R1 stopped pwm high count", hi, 0);
    check("R1 stopped irq count", ir, 0);
  endtask

  task automatic t_edge();
    int hi, ir;
    setup(1'b0, 1'b0, 3, 1);
    start();
    #1 check("R2 edge first sample count0<W", int'(pwm_o), 0);
    window(40, hi, ir);
    check("R2 edge high count P3 W1", hi, 30);
    check("R8 edge irq count", ir, 10);
    stop();
  endtask

  task automatic t_centre();
    int hi, ir;
    setup(1'b1, 1'b0, 3, 2);
    start();
    window(40, hi, ir);
    check("R3 centre high count P3 W2", hi, 20);
    check("R8 centre irq count", ir, 5);
    stop();
  endtask

  task automatic t_bounds();
    int hi, ir;
    setup(1'b0, 1'b0, 3, 0); start(); window(40, hi, ir); stop();
    check("R4 edge W0 high count", hi, 40);
    setup(1'b1, 1'b0, 3, 0); start(); window(40, hi, ir); stop();
    check("R4 centre W0 high count", hi, 40);
    setup(1'b0, 1'b0, 3, 4); start(); window(40, hi, ir); stop();
    check("R5 edge W>P high count", hi, 0);
    setup(1'b1, 1'b0, 3, 9); start(); window(40, hi, ir); stop();
    check("R5 centre W>P high count", hi, 0);
  endtask

  task automatic t_presc();
    int hi, ir;
    setup(1'b0, 1'b1, 1, 1);
    start();
    window(63, hi, ir);
    check("R6 no step before 64th clock", hi, 0);
    window(193, hi, ir);
    check("R6 slow high count", hi, 128);
    check("R8 slow irq single clocks", ir, 2);
    stop();
  endtask

  task automatic t_shadow();
    int hi, ir;
    setup(1'b0, 1'b0, 3, 1);
    start();
    @(posedge clk_i); #1;
    wr(1'b1, 16'd3);
    #1 check("R7 width held mid-period", int'(pwm_o), 1);
    @(posedge clk_i); #1;
    @(posedge clk_i); #1;
    check("R7 period end irq", int'(irq_o), 1);
    check("R7 new width at count0", int'(pwm_o), 0);
    window(4, hi, ir);
    check("R7 new width high count", hi, 1);
    stop();
  endtask

  initial begin
    #1 t_reset();
    #20 rst_ni = 1'b1;
    t_disabled();
    t_edge();
    t_centre();
    t_bounds();
    t_presc();
    t_shadow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule